// File: doc/BRIEF.md
# Frame-Pulse One-Second Timer

This block turns an 8 kHz frame pulse into two slow timing references for a controller that sends periodic performance reports. It runs on the 2.048 MHz bit clock and counts frame pulses. After every half second's worth of frames it inverts a square-wave output, so that output has a one-second period and is meant to drive a pin.

A second, slower bit inverts once for each full period of the square wave. It is meant to be read as a status flag. It does not flip at the same instant as the square wave rises. It flips a fixed number of bit-clock cycles after the frame pulse that produced the rising edge, which gives software a well-defined point within a frame at which the flag is known to have changed.

Each frame pulse restarts a bit counter within the frame, and that counter places the offset. A frame pulse that arrives before the usual 256 bit times have passed still counts as a frame. It also moves the offset reference to itself.

Top module: `fp_sec_timer`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, both `sec_out` and `tmr_bit` are 0.
- R2: `sec_out` inverts one cycle after the clock edge that samples the FRAMES_PER_HALF-th frame pulse since the last inversion or since reset, with a default of 4000. The first inversion after reset is a rise.
- R3: `sec_out` stays high for exactly FRAMES_PER_HALF frame pulses and low for exactly FRAMES_PER_HALF frame pulses, so one period is 2×FRAMES_PER_HALF frames.
- R4: `tmr_bit` inverts once for each rising edge of `sec_out` and never in response to a falling edge, so its period is twice that of `sec_out`.
- R5: `tmr_bit` inverts TOGGLE_OFFSET bit-clock cycles after the edge that sampled the frame pulse raising `sec_out`, with a default of 62. It keeps its old value one cycle before that point.
- R6: A frame pulse that arrives while the toggle is pending restarts the offset count. `tmr_bit` then inverts TOGGLE_OFFSET cycles after that newer pulse, not after the earlier one.
- R7: Every frame pulse counts toward the half-second total, including one that arrives before a full frame has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock, 2.048 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| fp | input | 1 | Frame pulse, high for one bit-clock cycle per frame |
| sec_out | output | 1 | One-second-period square wave |
| tmr_bit | output | 1 | Two-second-period status toggle |

## Verification
The assertions assume that `fp` is high for only one cycle at a time. They also assume that frame pulses are spaced so that FRAMES_PER_HALF pulses cannot occur inside a single TOGGLE_OFFSET window, which means a pending toggle always completes before the next rising edge. The bench drives `fp` as single-cycle pulses, normally 256 cycles apart. It shortens one gap, to 31 cycles, only to exercise the resynchronization case. The half-second count is reduced so that whole periods fit in a short run, while the frame length and offset keep their defaults.

// File: rtl/fp_sec_timer.sv
module fp_sec_timer #(
  parameter int BITS_PER_FRAME  = 256,
  parameter int FRAMES_PER_HALF = 4000,
  parameter int TOGGLE_OFFSET   = 62
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic fp,
  output logic sec_out,
  output logic tmr_bit
);
  localparam int BW = $clog2(BITS_PER_FRAME);
  localparam int FW = (FRAMES_PER_HALF > 1) ? $clog2(FRAMES_PER_HALF) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_FRAME - 1);
  localparam logic [BW-1:0] HIT_CNT  = BW'(TOGGLE_OFFSET - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES_PER_HALF - 1);

  logic [BW-1:0] bit_cnt;
  logic [FW-1:0] frm_cnt;
  logic          armed;

  wire half_done = fp && (frm_cnt == FRM_LAST);
  wire sec_rise  = half_done && !sec_out;
  wire fire      = armed && !fp && (bit_cnt == HIT_CNT);

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (fp) begin
      bit_cnt <= '0;
    end else if (bit_cnt != BIT_LAST) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      frm_cnt <= '0;
      sec_out <= 1'b0;
    end else if (fp) begin
      frm_cnt <= half_done ? '0 : frm_cnt + 1'b1;
      sec_out <= sec_out ^ half_done;
    end
  end

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      tmr_bit <= 1'b0;
    end else begin
      if (sec_rise) armed <= 1'b1;
      else if (fire) armed <= 1'b0;
      tmr_bit <= tmr_bit ^ fire;
    end
  end

  a_r2_sec_moves_on_fp: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(sec_out) |-> $past(fp));

  a_r3_frame_count_range: assert property (@(posedge bclk) disable iff (!rst_n)
    frm_cnt <= FRM_LAST);

  a_r4_tmr_only_in_high_half: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(tmr_bit) |-> (sec_out && $stable(sec_out)));

  a_r5_tmr_at_offset: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(tmr_bit) |-> ($past(bit_cnt) == HIT_CNT && !$past(fp)));

  a_r1_reset_clears: assert property (@(posedge bclk)
    !rst_n |=> (!sec_out && !tmr_bit));
endmodule

// File: tb/fp_sec_timer_tb.sv
module fp_sec_timer_tb_top;
  localparam int HALF = 4;
  logic bclk = 0;
  logic rst_n = 0;
  logic fp = 0;
  logic sec_out, tmr_bit;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 bclk = ~bclk;

  fp_sec_timer #(.BITS_PER_FRAME(256), .FRAMES_PER_HALF(HALF), .TOGGLE_OFFSET(62)) dut_i (
    .bclk(bclk), .rst_n(rst_n), .fp(fp), .sec_out(sec_out), .tmr_bit(tmr_bit));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge bclk);
  endtask

  task automatic send_fp();
    fp = 1;
    @(negedge bclk);
    fp = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(4);
    chk("R1 sec in reset", sec_out, 0);
    chk("R1 tmr in reset", tmr_bit, 0);
    rst_n = 1;
    step(1);
    chk("R1 sec after reset", sec_out, 0);
    chk("R1 tmr after reset", tmr_bit, 0);
  endtask

  task automatic t_first_second();
    for (int f = 0; f < HALF - 1; f++) begin
      send_fp();
      chk("R2 sec before count done", sec_out, 0);
      step(255);
    end
    send_fp();
    chk("R2 sec rises on last frame", sec_out, 1);
    chk("R5 tmr unchanged at pulse", tmr_bit, 0);
    step(61);
    chk("R5 tmr old one cycle early", tmr_bit, 0);
    step(1);
    chk("R5 tmr toggles at offset", tmr_bit, 1);
    step(193);
  endtask

  task automatic t_low_half();
    for (int f = 0; f < HALF - 1; f++) begin
      send_fp();
      chk("R3 sec stays high", sec_out, 1);
      step(255);
    end
    send_fp();
    chk("R3 sec falls after full high half", sec_out, 0);
    step(62);
    chk("R4 tmr ignores falling edge", tmr_bit, 1);
    step(193);
    chk("R4 tmr still held", tmr_bit, 1);
  endtask

  task automatic t_resync();
    for (int f = 0; f < HALF - 1; f++) begin
      send_fp();
      chk("R3 sec stays low", sec_out, 0);
      step(255);
    end
    send_fp();
    chk("R2 sec rises again", sec_out, 1);
    step(30);
    send_fp();
    chk("R6 tmr held at early pulse", tmr_bit, 1);
    step(31);
    chk("R6 no toggle at stale offset", tmr_bit, 1);
    step(30);
    chk("R6 tmr old just before new offset", tmr_bit, 1);
    step(1);
    chk("R6 tmr toggles after newer pulse", tmr_bit, 0);
    step(193);
  endtask

  task automatic t_early_counts();
    for (int f = 0; f < HALF - 2; f++) begin
      send_fp();
      chk("R7 sec high while counting", sec_out, 1);
      step(255);
    end
    send_fp();
    chk("R7 early pulse counted as frame", sec_out, 0);
    step(10);
  endtask

  initial begin
    step(1);
    t_reset();
    t_first_second();
    t_low_half();
    t_resync();
    t_early_counts();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge bclk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule